// File: doc/BRIEF.md
# Flash Page-Load Program Controller

This block is the control core of a byte-wide flash memory that is rewritten one page at a time. A host drives it like a static RAM, using active-low chip enable, output enable and write enable, an address and a data byte. Each qualified write strobe puts one byte into a page buffer. When the host stops strobing for a set number of clock cycles, the load window closes and a programming period begins. During that period the block writes the whole page into a behavioural memory array.

The strobes are synchronized to the system clock. Write strobes are detected as edges of the combined enable. The address is taken when the combined write strobe begins and the data byte when it ends. While programming runs, reads return a status poll and not array contents. Bytes of the target page that were not loaded become 0xFF.

Top module: `flash_page_prog`

## Requirements
- R1: `dq_oe` is high only when chip enable and output enable are both low and write enable is high, as seen through a two-flop synchronizer. Otherwise `dq_oe` is low.
- R2: A byte load needs chip enable and write enable both low while output enable is high. The strobe edge may come from either pin. With output enable low, no load takes place.
- R3: The address is captured when the combined write strobe becomes active. The data byte is captured when the strobe goes inactive, so later changes to the address, and data changed before the strobe ends, are handled that way.
- R4: Address bits [ADDR_W-1:6] select the page and bits [5:0] select the byte within the 64-byte page. Bytes may be loaded in any order.
- R5: Programming starts once no new write strobe has begun for LOAD_TIMEOUT cycles after the last strobe ended. A new strobe inside that window restarts the count.
- R6: At the end of a PROG_CYCLES programming period, every loaded byte of the page holds its loaded value. Every unloaded byte of that page reads 0xFF. All other pages are unchanged.
- R7: During programming, a read returns the complement of bit 7 of the last loaded byte on bit 7.
- R8: During programming, bits 5:0 of a read are 0. Bit 6 changes value between one read and the next.
- R9: Write strobes that occur during programming are ignored: they load nothing and start no new program cycle.
- R10: After reset the array reads 0xFF everywhere, no load is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in the low 6 bits |
| din | input | 8 | Write data byte |
| dq_o | output | 8 | Read data, or poll status while programming |
| dq_oe | output | 1 | Drive enable for `dq_o`; low means high impedance |

## Verification
Most faults in this block stay hidden until a page commits: a wrong valid bit, offset or page register only appears when the page is read back after the programming period. The array is therefore swept completely and compared with a model after each phase. A timer fault shows within one window: polling status appears too early, or never appears, at a read placed on either side of the timeout. A wrong toggle or status register shows at the second poll read.

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_BITS    = 6,
  parameter int LOAD_TIMEOUT = 64,
  parameter int PROG_CYCLES  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dq_o,
  output logic              dq_oe
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int PG_W    = ADDR_W - PAGE_BITS;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CMAX    = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
  localparam int CW      = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;

  state_t               state;
  logic [1:0]           ce_q, oe_q, we_q;
  logic                 wr_s, rd_s, wr_d, rd_d;
  logic                 wr_go, wr_done, rd_done, commit;
  logic [CW-1:0]        cnt;
  logic [PAGE_SZ-1:0]   vld;
  logic [PAGE_BITS-1:0] off;
  logic [PG_W-1:0]      pg;
  logic                 last7, tgl;
  logic [7:0]           pbuf [PAGE_SZ];
  logic [7:0]           mem  [DEPTH];

  assign wr_s    = !ce_q[1] && !we_q[1] && oe_q[1];
  assign rd_s    = !ce_q[1] && !oe_q[1] && we_q[1];
  assign wr_go   = wr_s && !wr_d;
  assign wr_done = !wr_s && wr_d;
  assign rd_done = !rd_s && rd_d;
  assign commit  = (state == S_PROG) && (cnt == CW'(PROG_CYCLES - 1));

  assign dq_oe = rd_s;
  assign dq_o  = (state == S_PROG) ? {~last7, tgl, 6'b0} : mem[addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_q <= 2'b11; oe_q <= 2'b11; we_q <= 2'b11;
    end else begin
      ce_q <= {ce_q[0], ce_n};
      oe_q <= {oe_q[0], oe_n};
      we_q <= {we_q[0], we_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; vld <= '0; off <= '0; pg <= '0;
      last7 <= 1'b0; tgl <= 1'b0; wr_d <= 1'b0; rd_d <= 1'b0;
    end else begin
      wr_d <= wr_s;
      rd_d <= rd_s;
      case (state)
        S_PROG: begin
          if (rd_done) tgl <= ~tgl;
          if (commit) begin
            state <= S_IDLE; vld <= '0; cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (wr_go) begin
            off   <= addr[PAGE_BITS-1:0];
            pg    <= addr[ADDR_W-1:PAGE_BITS];
            state <= S_LOAD;
            cnt   <= '0;
          end else if (state == S_LOAD) begin
            if (wr_s || wr_done) cnt <= '0;
            else if (cnt == CW'(LOAD_TIMEOUT - 1)) begin
              state <= S_PROG; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          if (state == S_LOAD && wr_done) begin
            vld[off] <= 1'b1;
            last7    <= din[7];
          end
        end
      endcase
    end

  always_ff @(posedge clk)
    if (state == S_LOAD && wr_done) pbuf[off] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_SZ; i++)
        mem[{pg, PAGE_BITS'(i)}] <= vld[i] ? pbuf[i] : 8'hFF;
    end

  // R1
  dq_oe_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && !oe_n && we_n, 2));

  // R9
  prog_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && $past(state == S_PROG)) |-> ($stable(vld) && $stable(pg)));

  // R5
  load_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD) |-> (cnt < CW'(LOAD_TIMEOUT)));

  // R6
  prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG) |=> (state == S_PROG || $past(cnt) == CW'(PROG_CYCLES - 1)));

  // R8
  poll_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PROG && rd_done && !commit) |=> (tgl != $past(tgl)));
endmodule

// File: tb/tb_flash_page_prog.sv
`timescale 1ns/1ps
module tb_flash_page_prog;
  localparam int LT = 64;
  localparam int PC = 200;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dq_o;
  logic dq_oe;
  logic [7:0] em [1 << AW];
  int nchk = 0, nfail = 0;
  logic [7:0] last_d;

  flash_page_prog #(.ADDR_W(AW), .PAGE_BITS(6), .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dq_o(dq_o), .dq_oe(dq_oe));

  always #2 clk = ~clk;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit cectl);
    addr = a; din = d; oe_n = 1;
    if (cectl) begin we_n = 0; tick(1); ce_n = 0; tick(6); ce_n = 1; tick(1); we_n = 1; end
    else       begin ce_n = 0; tick(1); we_n = 0; tick(6); we_n = 1; tick(1); ce_n = 1; end
    tick(5);
    last_d = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    addr = a; we_n = 1; ce_n = 0; oe_n = 0;
    tick(5);
    d = dq_o; oe = dq_oe;
    ce_n = 1; oe_n = 1;
    tick(4);
  endtask

  task automatic sweep(input string req);
    logic [7:0] d; logic oe;
    for (int a = 0; a < (1 << AW); a++) begin
      rd(AW'(a), d, oe);
      check(oe && d == em[a], req, {oe, d}, {1'b1, em[a]});
    end
  endtask

  task automatic polls(input int n);
    logic [7:0] d; logic oe; logic prev6;
    for (int k = 0; k < n; k++) begin
      rd('0, d, oe);
      check(d[7] == ~last_d[7], "R7 poll bit7", d[7], ~last_d[7]);
      check(d[5:0] == 6'd0, "R8 poll low bits", d[5:0], 0);
      if (k > 0) check(d[6] != prev6, "R8 poll toggle", d[6], ~prev6);
      prev6 = d[6];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d; logic oe;
    for (int a = 0; a < (1 << AW); a++) em[a] = 8'hFF;
    tick(3); rst_n = 1; tick(3);
    // R10 reset state
    check(dq_oe == 0, "R10 dq_oe after reset", dq_oe, 0);
    sweep("R10 erased array");

    // R1 output enable combinations
    ce_n = 0; oe_n = 1; we_n = 1; tick(5);
    check(dq_oe == 0, "R1 oe_n high", dq_oe, 0);
    ce_n = 1; oe_n = 0; tick(5);
    check(dq_oe == 0, "R1 ce_n high", dq_oe, 0);
    ce_n = 0; oe_n = 0; we_n = 1; tick(5);
    check(dq_oe == 1, "R1 read enabled", dq_oe, 1);
    // R2 write with oe low: no output, no load
    addr = AW'(9 * 64 + 4); din = 8'h00; we_n = 0; tick(6);
    check(dq_oe == 0, "R1 we_n low", dq_oe, 0);
    we_n = 1; ce_n = 1; oe_n = 1; tick(LT + 40);
    rd(AW'(9 * 64 + 4), d, oe);
    check(oe && d == 8'hFF, "R2 oe low blocks load", d, 8'hFF);

    // R4 full page 3 in scrambled order, R2 both strobe pins
    for (int i = 0; i < 64; i++) begin
      int o; o = (i * 37) % 64;
      wr(AW'(3 * 64 + o), 8'((i * 29 + 7) & 255), i[0]);
      em[3 * 64 + o] = 8'((i * 29 + 7) & 255);
    end
    tick(20);
    rd(AW'(3 * 64), d, oe);
    check(d == 8'hFF, "R5 no program before timeout", d, 8'hFF);
    tick(40);
    polls(4);
    tick(PC + LT);
    sweep("R6 R4 full page commit");

    // R3 address at strobe start, data at strobe end
    addr = AW'(5 * 64 + 10); din = 8'h11; oe_n = 1; ce_n = 0; tick(1);
    we_n = 0; tick(4);
    addr = AW'(5 * 64 + 20); din = 8'h5A; tick(4);
    we_n = 1; tick(1); ce_n = 1; tick(5);
    em[5 * 64 + 10] = 8'h5A;
    // R5 new strobe inside window restarts the count
    tick(LT - 20);
    wr(AW'(5 * 64 + 30), 8'hC3, 1'b0);
    em[5 * 64 + 30] = 8'hC3;
    tick(LT - 20);
    rd(AW'(5 * 64 + 40), d, oe);
    check(d == 8'hFF, "R5 window restarted", d, 8'hFF);
    tick(30);
    polls(2);
    tick(PC + LT);
    sweep("R3 capture edges");

    // R6 partial reload of page 3: unloaded bytes become 0xFF
    for (int o = 62; o >= 0; o -= 2) begin
      wr(AW'(3 * 64 + o), 8'((o * 5 + 1) & 255), o[1]);
      em[3 * 64 + o] = 8'((o * 5 + 1) & 255);
      em[3 * 64 + o + 1] = 8'hFF;
    end
    tick(70);
    polls(2);
    // R9 write during programming ignored
    wr(AW'(7 * 64 + 0), 8'h00, 1'b0);
    polls(2);
    tick(PC + LT + 40);
    rd(AW'(7 * 64), d, oe);
    check(oe && d == 8'hFF, "R9 strobe during program ignored", d, 8'hFF);
    sweep("R6 partial page and R9");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule